// File: doc/BRIEF.md
# Half-Cycle Carry-Save Counter

This block is a free-running binary counter meant to be driven by a fast local oscillator. In its default mode it advances on the rising clock edge and on the falling clock edge, so the count it reports is a number of half-cycles. Every stored bit is held in two single-edge flops, one clocked by each edge. Their exclusive-OR is the value the rest of the logic sees. Each flop loads the new value XORed with the other flop's content, so the visible bit takes the new value on whichever edge just fired.

The increment does not use a carry chain. The state is kept as a sum vector and a carry vector whose arithmetic sum is the count. One step of half-adders moves every carry up by one bit position and injects a new one at bit zero. The only wide add is the resolve step that forms the reported count from the two vectors. It sits outside the counting loop, so the loop depth does not grow with the counter width.

A parameter can turn off falling-edge counting. The counter then advances on rising edges only, which is useful when the falling-edge flops cannot keep up. A synchronous clear empties every flop of both polarities.

Top module: `hce_counter`

## Requirements
- R1: With the dual-edge parameter set (default) and clear low, the count rises by exactly one at every rising edge and at every falling edge of `clk`, and the new value is visible before the next edge of either polarity.
- R2: In dual-edge mode, bit 0 of the count changes at every clock edge, so its period equals one clock period, and bit N changes every 2^N edges, so its period is 2^N clock periods.
- R3: When `clear` is held high through a rising edge and the falling edge after it, the count is zero after that falling edge. Counting resumes with the value 1 at the first rising edge at which `clear` is low.
- R4: The count wraps from 2^WIDTH-1 to 0 on the next counted edge and keeps counting from there.
- R5: With the dual-edge parameter cleared, the count rises by one only on rising edges and is unchanged across falling edges, so bit 0 has a period of two clock periods.
- R6: The default width is 64 bits, and the reported count always equals the sum, modulo 2^WIDTH, of the stored sum and carry vectors. It therefore tracks a plain reference count exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; both edges are used in dual-edge mode |
| clear | input | 1 | Synchronous clear, sampled at both edges |
| count | output | WIDTH | Resolved count of half-cycles (or of cycles in single-edge mode) |

## Verification
Every counted edge changes the count through a single flop. The new value is therefore due just after the edge that caused it, with no added latency. The bench samples two nanoseconds after every rising edge and every falling edge and compares against a behavioural count that it advances at that same edge.

Clear takes a full clock cycle to act: the rising-edge flops empty at the rising edge and the falling-edge flops at the following falling edge. The zero is therefore checked only after that falling edge. Inputs are changed one nanosecond after a falling edge, so no input moves near an active edge.

// File: rtl/hce_pkg.sv
package hce_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic wipe;   // empty every flop of both polarities
    logic step;   // advance the carry-save state
  } hceStrobe_t;

endpackage

// File: rtl/hce_ctrl.sv
module hce_ctrl
  import hce_pkg::*;
(
  input  logic       clear,
  output hceStrobe_t strobes
);

  always_comb begin
    strobes.wipe = clear;
    strobes.step = ~clear;
  end

endmodule

// File: rtl/hce_cell.sv
// One stored bit. In dual-edge mode it is a pair of opposite-edge flops
// whose XOR is the visible value; otherwise it is a plain rising-edge flop.
module hce_cell #(
  parameter bit DUAL_EDGE = 1'b1
) (
  input  logic clk,
  input  logic wipe,
  input  logic nextVal,
  output logic curVal
);

  logic riseQ;

  if (DUAL_EDGE) begin : g_dual
    logic fallQ;

    always_ff @(posedge clk) begin
      if (wipe) riseQ <= 1'b0;
      else      riseQ <= nextVal ^ fallQ;
    end

    always_ff @(negedge clk) begin
      if (wipe) fallQ <= 1'b0;
      else      fallQ <= nextVal ^ riseQ;
    end

    assign curVal = riseQ ^ fallQ;
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (wipe) riseQ <= 1'b0;
      else      riseQ <= nextVal;
    end

    assign curVal = riseQ;
  end

endmodule

// File: rtl/hce_datapath.sv
module hce_datapath
  import hce_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter bit DUAL_EDGE = 1'b1
) (
  input  logic             clk,
  input  hceStrobe_t       strobes,
  output logic [WIDTH-1:0] count
);

  localparam int STATE_BITS = 2 * WIDTH;

  logic [WIDTH-1:0]      sumVec, carVec;
  logic [WIDTH-1:0]      sumNext, carNext;
  logic [STATE_BITS-1:0] stateNow, stateNext;

  // One layer of half-adders: each pair collapses to a sum bit and a carry
  // that moves up one position; a fresh carry enters at bit zero.
  always_comb begin
    sumNext    = sumVec ^ carVec;
    carNext    = {sumVec[WIDTH-2:0] & carVec[WIDTH-2:0], 1'b1};
    if (!strobes.step) begin
      sumNext = '0;
      carNext = '0;
    end
  end

  assign stateNext = {carNext, sumNext};
  assign sumVec    = stateNow[WIDTH-1:0];
  assign carVec    = stateNow[STATE_BITS-1:WIDTH];

  for (genvar b = 0; b < STATE_BITS; b++) begin : g_cells
    hce_cell #(.DUAL_EDGE(DUAL_EDGE)) u_cell (
      .clk     (clk),
      .wipe    (strobes.wipe),
      .nextVal (stateNext[b]),
      .curVal  (stateNow[b])
    );
  end

  // Resolve step: outside the counting loop.
  assign count = sumVec + carVec;

endmodule

// File: rtl/hce_counter.sv
module hce_counter
  import hce_pkg::*;
#(
  parameter int WIDTH     = 64,
  parameter bit DUAL_EDGE = 1'b1
) (
  input  logic             clk,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);

  hceStrobe_t strobes;

  hce_ctrl u_ctrl (
    .clear   (clear),
    .strobes (strobes)
  );

  hce_datapath #(.WIDTH(WIDTH), .DUAL_EDGE(DUAL_EDGE)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .count   (count)
  );

endmodule

// File: rtl/hce_counter_chk.sv
module hce_counter_chk #(
  parameter int WIDTH     = 64,
  parameter bit DUAL_EDGE = 1'b1
) (
  input logic             clk,
  input logic             clear,
  input logic [WIDTH-1:0] count
);

  localparam int STEP = DUAL_EDGE ? 2 : 1;

  logic negArmed = 1'b0;
  always_ff @(negedge clk) negArmed <= 1'b1;

  AST_STEP_RISE: assert property (@(posedge clk) disable iff (clear)
    !$past(clear) |-> count == WIDTH'($past(count) + STEP)) else $error("step across rising edges"); // R1

  AST_STEP_FALL: assert property (@(negedge clk) disable iff (clear)
    (negArmed && !$past(clear)) |-> count == WIDTH'($past(count) + STEP)) else $error("step across falling edges"); // R5

  AST_BIT0_PERIOD: assert property (@(posedge clk) disable iff (clear)
    (DUAL_EDGE && !$past(clear)) |-> count[0] == $past(count[0])) else $error("bit0 period"); // R2

  AST_CLEAR_ZERO: assert property (@(negedge clk)
    (negArmed && clear && $past(clear)) |-> count == '0) else $error("clear not zero"); // R3

endmodule

bind hce_counter hce_counter_chk #(.WIDTH(WIDTH), .DUAL_EDGE(DUAL_EDGE)) u_chk (
  .clk   (clk),
  .clear (clear),
  .count (count)
);

// File: tb/hce_counter_tb.sv
module hce_counter_tb;

  logic        clk = 1'b0;
  logic        clear = 1'b1;
  logic [63:0] cntWide;
  logic [7:0]  cntSmall;
  logic [7:0]  cntSingle;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  longint unsigned refWide;
  int refSmall, refSingle, edgeNum;

  always #5 clk = ~clk;

  hce_counter u_dut (.clk(clk), .clear(clear), .count(cntWide));
  hce_counter #(.WIDTH(8), .DUAL_EDGE(1'b1)) u_small  (.clk(clk), .clear(clear), .count(cntSmall));
  hce_counter #(.WIDTH(8), .DUAL_EDGE(1'b0)) u_single (.clk(clk), .clear(clear), .count(cntSingle));

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check64({"R1/R6 wide ", tag}, cntWide, refWide);
    check64({"R4 small ", tag}, {56'd0, cntSmall}, 64'(refSmall % 256));
    check64({"R5 single ", tag}, {56'd0, cntSingle}, 64'(refSingle % 256));
  endtask

  task automatic runCycles(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      refWide++; refSmall++; refSingle++; edgeNum++;
      checkAll("rise");
      // R2: bit 3 of the dual counter flips exactly every 8 edges
      check64("R2 bit3", {63'd0, cntSmall[3]}, 64'((refSmall / 8) % 2));
      @(negedge clk); #2;
      refWide++; refSmall++; edgeNum++;
      checkAll("fall");
      check64("R2 bit0", {63'd0, cntSmall[0]}, 64'(refSmall % 2));
    end
  endtask

  initial begin
    refWide = 0; refSmall = 0; refSingle = 0; edgeNum = 0;
    // R3: clear held over several full cycles from time zero
    repeat (3) @(negedge clk);
    #2;
    check64("R3 reset wide", cntWide, 64'd0);
    check64("R3 reset small", {56'd0, cntSmall}, 64'd0);
    check64("R3 reset single", {56'd0, cntSingle}, 64'd0);
    #(-1+1) clear = 1'b0;
    runCycles(40);

    // R3: clear mid-run, held over one rising and one falling edge
    @(negedge clk); #1 clear = 1'b1;
    @(negedge clk); #1;
    check64("R3 mid wide", cntWide, 64'd0);
    check64("R3 mid small", {56'd0, cntSmall}, 64'd0);
    check64("R3 mid single", {56'd0, cntSingle}, 64'd0);
    clear = 1'b0;
    refWide = 0; refSmall = 0; refSingle = 0;
    @(posedge clk); #2;
    refWide++; refSmall++; refSingle++;
    checkAll("resume");
    check64("R3 resume one", cntWide, 64'd1);
    @(negedge clk); #2;
    refWide++; refSmall++;
    checkAll("resume fall");

    // R4: run well past 256 edges and 256 rising edges so both 8-bit copies wrap
    runCycles(300);
    check64("R4 wrapped", {63'd0, (refSmall > 256 && refSingle > 256)}, 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule